// File: doc/BRIEF.md
# Bit-Transition Settling Mask for a Converter Output Word

This block sits between a parallel analog-to-digital converter and whatever reads its samples. It samples the converter word on every system clock and watches one chosen bit of it. When that bit flips, in either direction, the converter's internal residue is probably still settling and the next few words may be out of order. The block then raises a busy flag for a programmable number of clock cycles. While the flag is high, the last word taken before the flip stays frozen on the output, and the reader must treat the sample stream as invalid.

The watched bit index and the busy length in clock cycles are runtime inputs. A busy length of zero turns the masking off. A flip that arrives while the flag is already high restarts the count at the full length. The output word and the flag leave the block through registers, so they stay aligned with each other and trail the input by one clock.

Top module: `adcSettleGuard`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `busy`=0 and `heldWord`=0. The first sample after reset is only recorded as the reference bit, so it never raises `busy`, whatever value the watched bit has.
- R2: When the watched bit goes from 0 to 1 between two consecutive samples taken outside reset, and `busyLen` is nonzero at the second sample, `busy` is 1 in the cycle after that second sample.
- R3: When the watched bit goes from 1 to 0 under the same conditions as R2, `busy` likewise rises in the cycle after the sample that shows the change.
- R4: After a transition sampled with `busyLen`=L (1 to 255), and with no further transition, `busy` stays high for exactly L consecutive cycles and then returns to 0.
- R5: A transition sampled while `busy` is high restarts the count, so `busy` stays high for the full `busyLen` cycles counted from the new transition.
- R6: While `busy` is high, `heldWord` keeps the last word that was sampled before the transition sample, and does not change.
- R7: While `busy` is low, `heldWord` equals the `adcWord` sampled one clock earlier.
- R8: A transition sampled with `busyLen`=0 leaves `busy` at 0 in the next cycle, and the word passes through as in R7.
- R9: `selIdx` chooses the watched bit by its index, where index 0 is the least significant bit. Changes in any other bit never raise `busy`. An index of `WORD_W` or more selects bit `DEF_SEL` (default 4).
- R10: `busyLen` is taken only at the sample where a transition is seen. Changing it while `busy` is high does not change the length of the window that is already running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adcWord | input | WORD_W | Converter output word, sampled every clock |
| selIdx | input | SEL_W | Index of the watched bit; out-of-range values fall back to DEF_SEL |
| busyLen | input | CNT_W | Busy window length in clock cycles; 0 disables masking |
| busy | output | 1 | High while the output word must be ignored |
| heldWord | output | WORD_W | Passed-through word, frozen while busy is high |

## Verification
The bench compares both outputs against a scoreboard in every cycle. A stale reference bit or a missed transition therefore shows up one clock after the sample that flips the bit, as a busy flag that is 0 where 1 is expected. A counter that is off by one shows up at the last cycle of the window. A wrong load strobe shows up as a word that moves while busy is high, or as a stale word once the flag drops. Retriggering, a length change during the window, a zero length, an out-of-range index and a reset in the middle of a window are each driven on purpose, so a fault in any of them shows up within a few cycles of its stimulus.

// File: rtl/settleGuardPkg.sv
package settleGuardPkg;

  // Strobes that the control side hands to the datapath each cycle.
  typedef struct packed {
    logic loadWord;   // capture the incoming word into the output register
  } guardStrobes_t;

endpackage

// File: rtl/settleDatapath.sv
module settleDatapath
  import settleGuardPkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int SEL_W   = 4,
  parameter int DEF_SEL = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] adcWord,
  input  logic [SEL_W-1:0]  selIdx,
  input  guardStrobes_t     strobes,
  output logic              watchedBit,
  output logic [WORD_W-1:0] heldWord
);

  localparam logic [SEL_W:0]   WORD_LIMIT = (SEL_W+1)'(WORD_W);
  localparam logic [SEL_W-1:0] FALLBACK   = SEL_W'(DEF_SEL);

  logic [SEL_W-1:0]  selEff;
  logic [WORD_W-1:0] bitHit;
  logic [WORD_W-1:0] wordQ;

  // Out-of-range index falls back to the default watched bit.
  always_comb begin
    if ({1'b0, selIdx} < WORD_LIMIT) selEff = selIdx;
    else                             selEff = FALLBACK;
  end

  // One AND term per bit position, reduced into the watched bit.
  for (genvar g = 0; g < WORD_W; g++) begin : g_pick
    assign bitHit[g] = adcWord[g] & (selEff == SEL_W'(g));
  end

  assign watchedBit = |bitHit;

  always_ff @(posedge clk) begin
    if (rst)                   wordQ <= '0;
    else if (strobes.loadWord) wordQ <= adcWord;
  end

  assign heldWord = wordQ;

endmodule

// File: rtl/settleControl.sv
module settleControl
  import settleGuardPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             watchedBit,
  input  logic [CNT_W-1:0] busyLen,
  output guardStrobes_t    strobes,
  output logic             busy
);

  logic             primed;    // a reference bit has been captured since reset
  logic             prevBit;   // watched bit from the previous sample
  logic [CNT_W-1:0] remain;    // busy cycles still to go
  logic [CNT_W-1:0] remainNext;
  logic             toggled;
  logic             busyQ;

  assign toggled = primed & (watchedBit ^ prevBit);

  always_comb begin
    if (toggled)             remainNext = busyLen;
    else if (remain != '0)   remainNext = remain - 1'b1;
    else                     remainNext = remain;
  end

  // The word register only follows the input when no window is open next cycle.
  always_comb begin
    strobes          = '0;
    strobes.loadWord = (remainNext == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed  <= 1'b0;
      prevBit <= 1'b0;
      remain  <= '0;
      busyQ   <= 1'b0;
    end else begin
      primed  <= 1'b1;
      prevBit <= watchedBit;
      remain  <= remainNext;
      busyQ   <= (remainNext != '0);
    end
  end

  assign busy = busyQ;

endmodule

// File: rtl/adcSettleGuard.sv
module adcSettleGuard
  import settleGuardPkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int CNT_W   = 8,
  parameter int DEF_SEL = 4,
  localparam int SEL_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] adcWord,
  input  logic [SEL_W-1:0]  selIdx,
  input  logic [CNT_W-1:0]  busyLen,
  output logic              busy,
  output logic [WORD_W-1:0] heldWord
);

  guardStrobes_t strobes;
  logic          watchedBit;

  settleDatapath #(
    .WORD_W (WORD_W),
    .SEL_W  (SEL_W),
    .DEF_SEL(DEF_SEL)
  ) u_data (
    .clk       (clk),
    .rst       (rst),
    .adcWord   (adcWord),
    .selIdx    (selIdx),
    .strobes   (strobes),
    .watchedBit(watchedBit),
    .heldWord  (heldWord)
  );

  settleControl #(
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .watchedBit(watchedBit),
    .busyLen   (busyLen),
    .strobes   (strobes),
    .busy      (busy)
  );

endmodule

// File: rtl/adcSettleGuardChk.sv
module adcSettleGuardChk #(
  parameter int WORD_W  = 12,
  parameter int CNT_W   = 8,
  parameter int DEF_SEL = 4,
  parameter int SEL_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] adcWord,
  input logic [SEL_W-1:0]  selIdx,
  input logic [CNT_W-1:0]  busyLen,
  input logic              busy,
  input logic [WORD_W-1:0] heldWord
);

  logic              live;
  logic              lastBit;
  logic [WORD_W-1:0] lastWord;
  logic              curBit;

  // Port-level view of the watched bit, taken from the selection rule of R9.
  always_comb begin
    curBit = adcWord[DEF_SEL];
    for (int i = 0; i < WORD_W; i++) begin
      if (int'(selIdx) == i) curBit = adcWord[i];
    end
  end

  always_ff @(posedge clk) begin
    live     <= !rst;
    lastBit  <= curBit;
    lastWord <= adcWord;
  end

  // R1: reset clears both outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!busy && heldWord == '0));

  // R2 / R3: a flip of the watched bit with a nonzero length opens a window
  p_edge_opens_r2: assert property (@(posedge clk) disable iff (rst)
    (live && (curBit != lastBit) && (busyLen != '0)) |=> busy);

  // R6: the word is frozen while busy is high
  p_hold_word_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> $stable(heldWord));

  // R7: outside a window the word trails the input by one clock
  p_pass_word_r7: assert property (@(posedge clk) disable iff (rst)
    (live && !busy) |-> (heldWord == lastWord));

  // R8: a zero length never opens a window
  p_zero_len_r8: assert property (@(posedge clk) disable iff (rst)
    (live && (curBit != lastBit) && (busyLen == '0)) |=> !busy);

endmodule

bind adcSettleGuard adcSettleGuardChk #(
  .WORD_W (WORD_W),
  .CNT_W  (CNT_W),
  .DEF_SEL(DEF_SEL),
  .SEL_W  (SEL_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .adcWord (adcWord),
  .selIdx  (selIdx),
  .busyLen (busyLen),
  .busy    (busy),
  .heldWord(heldWord)
);

// File: tb/sim_adcSettleGuard.sv
module sim_adcSettleGuard;

  localparam int WORD_W  = 12;
  localparam int CNT_W   = 8;
  localparam int DEF_SEL = 4;
  localparam int SEL_W   = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [WORD_W-1:0] adcWord = '0;
  logic [SEL_W-1:0]  selIdx = SEL_W'(DEF_SEL);
  logic [CNT_W-1:0]  busyLen = '0;
  logic              busy;
  logic [WORD_W-1:0] heldWord;

  always #10 clk = ~clk;   // 50 MHz

  adcSettleGuard #(
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W),
    .DEF_SEL(DEF_SEL)
  ) u0 (
    .clk     (clk),
    .rst     (rst),
    .adcWord (adcWord),
    .selIdx  (selIdx),
    .busyLen (busyLen),
    .busy    (busy),
    .heldWord(heldWord)
  );

  typedef struct {
    logic              expBusy;
    logic [WORD_W-1:0] expWord;
    string             tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // Reference state, kept from the requirements.
  bit              mPrimed = 0;
  bit              mPrev = 0;
  int              mRemain = 0;
  logic [WORD_W-1:0] mWord = '0;

  // Driver: applies one vector at the falling edge and predicts the outputs
  // that appear after the next rising edge.
  task automatic apply(input logic [WORD_W-1:0] w, input int sel, input int len,
                       input bit r, input string tag);
    expItem_t it;
    int selEff;
    bit cur;
    @(negedge clk);
    adcWord = w;
    selIdx  = SEL_W'(sel);
    busyLen = CNT_W'(len);
    rst     = r;
    if (r) begin
      mPrimed = 0; mPrev = 0; mRemain = 0; mWord = '0;
    end else begin
      selEff = (sel < WORD_W) ? sel : DEF_SEL;
      cur = w[selEff];
      if (mPrimed && cur != mPrev) mRemain = len;
      else if (mRemain > 0)        mRemain = mRemain - 1;
      if (mRemain == 0) mWord = w;
      mPrev = cur;
      mPrimed = 1;
    end
    it.expBusy = (mRemain != 0);
    it.expWord = mWord;
    it.tag = tag;
    scoreQ.push_back(it);
  endtask

  // Monitor: samples a quarter period after each rising edge.
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #5;
      if (scoreQ.size() > 0) begin
        it = scoreQ.pop_front();
        vectors++;
        if (busy !== it.expBusy || heldWord !== it.expWord) begin
          miscompares++;
          $display("FAIL %s: busy=%0b heldWord=%03h, expected busy=%0b heldWord=%03h",
                   it.tag, busy, heldWord, it.expBusy, it.expWord);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then a first sample with the watched bit set
    for (int i = 0; i < 3; i++) apply(12'h010, 4, 3, 1, "R1 reset");
    apply(12'h010, 4, 3, 0, "R1 first sample no trigger");
    apply(12'h011, 4, 3, 0, "R7 pass through");
    apply(12'h012, 4, 3, 0, "R7 pass through");

    // R3: falling transition, length 3
    apply(12'h005, 4, 3, 0, "R3 falling opens");
    for (int i = 0; i < 5; i++) apply(12'h006 + 12'(i), 4, 3, 0, "R4 R6 window len 3");

    // R2: rising transition, length 5
    apply(12'h01A, 4, 5, 0, "R2 rising opens");
    for (int i = 0; i < 7; i++) apply(12'h0F0 + 12'(i), 4, 5, 0, "R4 R6 window len 5");

    // R5: retrigger inside a window
    apply(12'h0E0, 4, 4, 0, "R5 first edge");
    apply(12'h0E1, 4, 4, 0, "R5 inside");
    apply(12'h0F2, 4, 4, 0, "R5 retrigger");
    for (int i = 0; i < 6; i++) apply(12'h0F3, 4, 4, 0, "R5 restarted window");

    // R10: length changed while a window runs
    apply(12'h0E3, 4, 6, 0, "R10 open len 6");
    for (int i = 0; i < 8; i++) apply(12'h0E4 + 12'(i), 4, 1, 0, "R10 len change ignored");

    // R8: zero length disables masking
    apply(12'h3F0, 4, 0, 0, "R8 zero length edge");
    apply(12'h3E1, 4, 0, 0, "R8 zero length edge");
    apply(12'h3E2, 4, 0, 0, "R8 pass through");

    // R9: other bits toggling with bit 7 watched, then bit 7 flips
    for (int i = 0; i < 6; i++)
      apply((i % 2 == 0) ? 12'h010 : 12'h06F, 7, 3, 0, "R9 unwatched bits ignored");
    apply(12'h080, 7, 3, 0, "R9 watched bit 7 flips");
    for (int i = 0; i < 4; i++) apply(12'h080, 7, 3, 0, "R9 window on bit 7");

    // R9: out-of-range index falls back to bit 4
    apply(12'h000, 14, 2, 0, "R9 fallback settle");
    apply(12'h000, 14, 2, 0, "R9 fallback settle");
    apply(12'h010, 14, 2, 0, "R9 fallback bit 4 flips");
    for (int i = 0; i < 3; i++) apply(12'h011, 14, 2, 0, "R9 fallback window");

    // R4: shortest and longest windows
    apply(12'h001, 4, 1, 0, "R4 len 1 edge");
    apply(12'h002, 4, 1, 0, "R4 len 1 end");
    apply(12'h003, 4, 1, 0, "R4 len 1 pass");
    apply(12'h013, 4, 255, 0, "R4 len 255 edge");
    for (int i = 0; i < 257; i++) apply(12'h013 + 12'(i % 3), 4, 255, 0, "R4 len 255 window");

    // R1: reset in the middle of a window
    apply(12'h003, 4, 9, 0, "R1 open before reset");
    apply(12'h004, 4, 9, 0, "R1 open before reset");
    apply(12'h004, 4, 9, 1, "R1 reset mid window");
    apply(12'h000, 4, 9, 0, "R1 first sample after reset");
    apply(12'h001, 4, 9, 0, "R7 after reset");

    while (scoreQ.size() > 0) @(posedge clk);
    @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule